// File: doc/BRIEF.md
# Stream-to-memory burst write engine

This block moves a packet arriving on a streaming data input into memory over a write-only AXI4 master port. Software or an upstream engine hands it a transfer command that holds a word-aligned start address, a byte count and a small tag. Payload beats are taken from the stream into a short internal FIFO. The block then writes them out as INCR bursts of full-width words. It splits one command into as many child bursts as it needs so that no burst exceeds the beat limit or crosses a 4 KB page. It issues one child burst at a time and waits for its write response before it plans the next one. When the last response of a command has arrived, it returns a single status beat that carries the tag and the error flags gathered across all child bursts.

Address issue is gated by an external permission input, so a system arbiter can hold back memory traffic. Three one-cycle side-band outputs let surrounding logic follow progress: address posted, burst length loaded, and transfer done. When no command is active, the block takes only a small prefetch of payload beats and then throttles the stream. Commands should therefore arrive ahead of their data.

Top module: `s2mm_burst_writer`

## Requirements
- R1: The write address channel raises aw_valid only after a command has been accepted and after allow_addr_req was high in the previous cycle. While allow_addr_req stays low, no address is issued.
- R2: addr_posted is high for exactly the cycles in which an address handshake (aw_valid and aw_ready) takes place. Once raised, aw_valid, aw_addr and aw_len hold until aw_ready.
- R3: While no command is active and none has been accepted since the last status, at most 4 payload beats are accepted. After that, in_tready stays low until a command is accepted.
- R4: Payload beats leave on the write data channel in arrival order. w_data equals in_tdata and w_strb equals in_tkeep of the same beat. w_last is high on the final beat of each child burst.
- R5: next_len_load pulses in each address handshake cycle, with next_len equal to the aw_len of that burst.
- R6: Each burst has aw_size 2 (4-byte beats), aw_burst 2'b01 (INCR) and at most 16 beats, and it never crosses a 4 KB boundary. The bursts of a command start at its address, follow each other contiguously and together cover ceil(byte count / 4) beats. Each burst takes the largest length that these limits allow.
- R7: At most one burst is outstanding: no new address is issued while a write response is awaited. xfer_done pulses in the response handshake cycle of the last child burst of a command, and at no other time.
- R8: After every child burst of a command has received its response, exactly one status beat with sts_last high is offered. It is held stable until sts_ready, and statuses follow command order.
- R9: The status word holds the tag in bits 3:0. Bit 4 is set if any child response was SLVERR (2'b10) or DECERR (2'b11). Bit 5 is set if any beat had in_tkeep of 4'h0, or a partial in_tkeep without in_tlast. Bit 6 is set if in_tlast was high on a beat other than the command's final beat, or low on its final beat. Bit 7 is set only when bits 6:4 are all clear.
- R10: The command word is {address[31:0], byte_count[22:0], tag[3:0]} with the tag in the low bits. cmd_ready is high only while no command is active, so one command is processed at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command stream valid |
| cmd_ready | output | 1 | Command stream ready |
| cmd_data | input | 59 | Command word {address, byte count, tag} |
| allow_addr_req | input | 1 | Permission to issue a write address |
| in_tvalid | input | 1 | Payload stream valid |
| in_tready | output | 1 | Payload stream ready |
| in_tdata | input | 32 | Payload data |
| in_tkeep | input | 4 | Payload byte keep |
| in_tlast | input | 1 | Payload end of packet |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr | output | 32 | Burst start address |
| aw_len | output | 8 | Burst length minus one |
| aw_size | output | 3 | Beat size code |
| aw_burst | output | 2 | Burst type (INCR) |
| w_valid | output | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_data | output | 32 | Write data |
| w_strb | output | 4 | Write byte strobes |
| w_last | output | 1 | Final beat of burst |
| b_valid | input | 1 | Write response valid |
| b_ready | output | 1 | Write response ready |
| b_resp | input | 2 | Write response code |
| sts_valid | output | 1 | Status stream valid |
| sts_ready | input | 1 | Status stream ready |
| sts_data | output | 8 | Status word |
| sts_last | output | 1 | Status end of packet (always high with valid) |
| addr_posted | output | 1 | Pulse: address handed to memory side |
| xfer_done | output | 1 | Pulse: last child burst of a command completed |
| next_len_load | output | 1 | Pulse: burst length presented on next_len |
| next_len | output | 8 | Length of the burst being posted |

## Verification
The bench builds the block with its default parameters: 32-bit data, a 16-beat burst ceiling, a 4 KB page, an 8-entry FIFO and a prefetch of 4 beats. The small FIFO and prefetch values make the throttle point easy to reach in a few cycles. With the 16-beat ceiling, a byte count of about 100 already yields a split into two bursts. Start addresses are placed a few words below a page end, so the 4 KB cut produces one-beat and two-beat child bursts. The random memory stalls and error responses then drive the status aggregation through all of its flag combinations.

// File: rtl/s2mm_pkg.sv
package s2mm_pkg;

  typedef enum logic [2:0] {
    WR_IDLE,   // waiting for a command
    WR_PLAN,   // burst sized, waiting for address permission
    WR_ADDR,   // address offered on the write address channel
    WR_DATA,   // moving the burst's beats
    WR_RESP,   // waiting for the burst's write response
    WR_STS     // offering the command status
  } wr_state_e;

  // status flag offsets above the tag field
  localparam int STS_RESP_OFS = 0;
  localparam int STS_KEEP_OFS = 1;
  localparam int STS_LAST_OFS = 2;
  localparam int STS_OK_OFS   = 3;

endpackage

// File: rtl/s2mm_fifo.sv
module s2mm_fifo #(
  parameter int WIDTH = 37,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [PTR_W:0]   cnt_q, cnt_d;

  assign full  = (cnt_q == (PTR_W+1)'(DEPTH));
  assign empty = (cnt_q == '0);
  assign dout  = mem_q[rd_q];

  always_comb begin
    wr_d  = push ? wr_q + PTR_W'(1) : wr_q;
    rd_d  = pop  ? rd_q + PTR_W'(1) : rd_q;
    cnt_d = cnt_q;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + (PTR_W+1)'(1);
      2'b01:   cnt_d = cnt_q - (PTR_W+1)'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_q] <= din;
  end
endmodule

// File: rtl/s2mm_burst_planner.sv
module s2mm_burst_planner #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 22,
  parameter int MAX_BEATS  = 16,
  parameter int BOUNDARY   = 4096,
  parameter int BEAT_SHIFT = 2,
  parameter int CNT_W      = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] words_left,
  output logic [CNT_W-1:0]  beats
);
  localparam int BND_SHIFT = $clog2(BOUNDARY);
  localparam int BND_W     = BND_SHIFT - BEAT_SHIFT + 1;

  logic [BND_W-1:0]  to_bnd;
  logic [WORD_W-1:0] lim;

  always_comb begin
    to_bnd = BND_W'(BOUNDARY >> BEAT_SHIFT)
           - BND_W'(addr[BND_SHIFT-1:BEAT_SHIFT]);
    lim = WORD_W'(MAX_BEATS);
    if (words_left < lim)         lim = words_left;
    if (WORD_W'(to_bnd) < lim)    lim = WORD_W'(to_bnd);
    beats = CNT_W'(lim);
  end
endmodule

// File: rtl/s2mm_burst_writer.sv
module s2mm_burst_writer
  import s2mm_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int BTT_W      = 23,
  parameter int TAG_W      = 4,
  parameter int MAX_BEATS  = 16,
  parameter int BOUNDARY   = 4096,
  parameter int FIFO_DEPTH = 8,
  parameter int PREFETCH   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  output logic                          cmd_ready,
  input  logic [ADDR_W+BTT_W+TAG_W-1:0] cmd_data,
  input  logic                          allow_addr_req,
  input  logic                          in_tvalid,
  output logic                          in_tready,
  input  logic [DATA_W-1:0]             in_tdata,
  input  logic [DATA_W/8-1:0]           in_tkeep,
  input  logic                          in_tlast,
  output logic                          aw_valid,
  input  logic                          aw_ready,
  output logic [ADDR_W-1:0]             aw_addr,
  output logic [7:0]                    aw_len,
  output logic [2:0]                    aw_size,
  output logic [1:0]                    aw_burst,
  output logic                          w_valid,
  input  logic                          w_ready,
  output logic [DATA_W-1:0]             w_data,
  output logic [DATA_W/8-1:0]           w_strb,
  output logic                          w_last,
  input  logic                          b_valid,
  output logic                          b_ready,
  input  logic [1:0]                    b_resp,
  output logic                          sts_valid,
  input  logic                          sts_ready,
  output logic [TAG_W+3:0]              sts_data,
  output logic                          sts_last,
  output logic                          addr_posted,
  output logic                          xfer_done,
  output logic                          next_len_load,
  output logic [7:0]                    next_len
);
  localparam int STRB_W     = DATA_W / 8;
  localparam int BEAT_SHIFT = $clog2(STRB_W);
  localparam int WORD_W     = BTT_W + 1 - BEAT_SHIFT;
  localparam int CNT_W      = $clog2(MAX_BEATS + 1);
  localparam int PRE_W      = $clog2(PREFETCH + 1);
  localparam int FIFO_W     = DATA_W + STRB_W + 1;

  wr_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [WORD_W-1:0] words_q, words_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [CNT_W-1:0]  len_q, len_d;
  logic [CNT_W-1:0]  beat_q, beat_d;
  logic [PRE_W-1:0]  pre_q, pre_d;
  logic              rerr_q, rerr_d, kerr_q, kerr_d, lerr_q, lerr_d;

  logic              cmd_fire, push, pop, aw_fire, b_fire, sts_fire;
  logic              f_full, f_empty, f_last, keep_bad, cmd_end_beat;
  logic [FIFO_W-1:0] f_dout;
  logic [STRB_W-1:0] f_keep;
  logic [CNT_W-1:0]  plan_beats;
  logic [BTT_W:0]    btt_round;

  // command fields: tag low, byte count, address high
  assign btt_round = {1'b0, cmd_data[TAG_W +: BTT_W]} + (BTT_W+1)'(STRB_W - 1);

  s2mm_fifo #(.WIDTH(FIFO_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push(push), .din({in_tlast, in_tkeep, in_tdata}),
    .pop(pop), .dout(f_dout), .full(f_full), .empty(f_empty)
  );

  s2mm_burst_planner #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .MAX_BEATS(MAX_BEATS),
    .BOUNDARY(BOUNDARY), .BEAT_SHIFT(BEAT_SHIFT), .CNT_W(CNT_W)
  ) plan_i (
    .addr(addr_q), .words_left(words_q), .beats(plan_beats)
  );

  assign f_last  = f_dout[FIFO_W-1];
  assign f_keep  = f_dout[DATA_W +: STRB_W];

  assign cmd_ready = (state_q == WR_IDLE);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign in_tready = !f_full && ((state_q != WR_IDLE) || (pre_q < PRE_W'(PREFETCH)));
  assign push      = in_tvalid && in_tready;

  assign aw_valid  = (state_q == WR_ADDR);
  assign aw_addr   = addr_q;
  assign aw_len    = 8'(len_q);
  assign aw_size   = 3'(BEAT_SHIFT);
  assign aw_burst  = 2'b01;
  assign aw_fire   = aw_valid && aw_ready;

  assign w_valid   = (state_q == WR_DATA) && !f_empty;
  assign w_data    = f_dout[DATA_W-1:0];
  assign w_strb    = f_keep;
  assign w_last    = (beat_q == len_q);
  assign pop       = w_valid && w_ready;

  assign b_ready   = (state_q == WR_RESP);
  assign b_fire    = b_valid && b_ready;

  assign sts_valid = (state_q == WR_STS);
  assign sts_last  = 1'b1;
  assign sts_fire  = sts_valid && sts_ready;
  assign sts_data  = {!(rerr_q || kerr_q || lerr_q), lerr_q, kerr_q, rerr_q, tag_q};

  assign addr_posted   = aw_fire;
  assign next_len_load = aw_fire;
  assign next_len      = aw_len;
  assign xfer_done     = b_fire && (words_q == '0);

  // words_q is already reduced by the current burst during the data phase
  assign cmd_end_beat = w_last && (words_q == '0);
  assign keep_bad     = (f_keep == '0) || (!f_last && (f_keep != '1));

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    words_d = words_q;
    tag_d   = tag_q;
    len_d   = len_q;
    beat_d  = beat_q;
    pre_d   = pre_q;
    rerr_d  = rerr_q;
    kerr_d  = kerr_q;
    lerr_d  = lerr_q;

    if (cmd_fire)                          pre_d = '0;
    else if (state_q == WR_IDLE && push)   pre_d = pre_q + PRE_W'(1);

    case (state_q)
      WR_IDLE: if (cmd_fire) begin
        addr_d  = cmd_data[TAG_W+BTT_W +: ADDR_W];
        words_d = btt_round[BTT_W:BEAT_SHIFT];
        tag_d   = cmd_data[TAG_W-1:0];
        rerr_d  = 1'b0;
        kerr_d  = 1'b0;
        lerr_d  = 1'b0;
        state_d = WR_PLAN;
      end
      WR_PLAN: if (allow_addr_req) begin
        len_d   = plan_beats - CNT_W'(1);
        state_d = WR_ADDR;
      end
      WR_ADDR: if (aw_fire) begin
        addr_d  = addr_q + (ADDR_W'(len_q) + ADDR_W'(1) << BEAT_SHIFT);
        words_d = words_q - (WORD_W'(len_q) + WORD_W'(1));
        beat_d  = '0;
        state_d = WR_DATA;
      end
      WR_DATA: if (pop) begin
        if (keep_bad)                 kerr_d = 1'b1;
        if (f_last != cmd_end_beat)   lerr_d = 1'b1;
        beat_d = beat_q + CNT_W'(1);
        if (w_last) state_d = WR_RESP;
      end
      WR_RESP: if (b_fire) begin
        if (b_resp[1]) rerr_d = 1'b1;
        state_d = (words_q == '0) ? WR_STS : WR_PLAN;
      end
      WR_STS: if (sts_fire) state_d = WR_IDLE;
      default: state_d = WR_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WR_IDLE;
      addr_q  <= '0;
      words_q <= '0;
      tag_q   <= '0;
      len_q   <= '0;
      beat_q  <= '0;
      pre_q   <= '0;
      rerr_q  <= 1'b0;
      kerr_q  <= 1'b0;
      lerr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      words_q <= words_d;
      tag_q   <= tag_d;
      len_q   <= len_d;
      beat_q  <= beat_d;
      pre_q   <= pre_d;
      rerr_q  <= rerr_d;
      kerr_q  <= kerr_d;
      lerr_q  <= lerr_d;
    end
  end
endmodule

// File: rtl/s2mm_burst_writer_chk.sv
module s2mm_burst_writer_chk #(
  parameter int ADDR_W     = 32,
  parameter int STS_W      = 8,
  parameter int MAX_BEATS  = 16,
  parameter int BOUNDARY   = 4096,
  parameter int PREFETCH   = 4,
  parameter int BEAT_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              allow_addr_req,
  input logic              in_tvalid,
  input logic              in_tready,
  input logic              aw_valid,
  input logic              aw_ready,
  input logic [ADDR_W-1:0] aw_addr,
  input logic [7:0]        aw_len,
  input logic              b_valid,
  input logic              b_ready,
  input logic              sts_valid,
  input logic              sts_ready,
  input logic [STS_W-1:0]  sts_data,
  input logic              sts_last,
  input logic              addr_posted,
  input logic              next_len_load,
  input logic [7:0]        next_len,
  input logic              xfer_done
);
  localparam int BND_SHIFT = $clog2(BOUNDARY);

  logic [31:0] end_off;
  logic [31:0] idle_beats_q;

  always_comb
    end_off = 32'(aw_addr[BND_SHIFT-1:0]) + (32'(aw_len) + 32'd1) * 32'(BEAT_BYTES);

  // beats taken since the last command acceptance while no command was active
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             idle_beats_q <= '0;
    else if (cmd_valid && cmd_ready)        idle_beats_q <= '0;
    else if (cmd_ready && in_tvalid && in_tready) idle_beats_q <= idle_beats_q + 32'd1;
  end

  a_r1_aw_after_allow: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aw_valid) |-> $past(allow_addr_req));

  a_r2_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid && !aw_ready |=> aw_valid && $stable(aw_addr) && $stable(aw_len));

  a_r2_posted_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    addr_posted |-> aw_valid && aw_ready);

  a_r3_prefetch_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready && idle_beats_q >= 32'(PREFETCH) |-> !in_tready);

  a_r5_len_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    next_len_load |-> addr_posted && next_len == aw_len);

  a_r6_burst_fits: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> (32'(aw_len) < 32'(MAX_BEATS)) && (end_off <= 32'(BOUNDARY)));

  a_r7_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> !b_ready);

  a_r7_done_on_resp: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> b_valid && b_ready);

  a_r8_sts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid && !sts_ready |=> sts_valid && $stable(sts_data));

  a_r8_sts_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
    sts_valid |-> sts_last);

  a_r10_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready);
endmodule

bind s2mm_burst_writer s2mm_burst_writer_chk #(
  .ADDR_W(ADDR_W), .STS_W(TAG_W + 4), .MAX_BEATS(MAX_BEATS),
  .BOUNDARY(BOUNDARY), .PREFETCH(PREFETCH), .BEAT_BYTES(DATA_W / 8)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .allow_addr_req(allow_addr_req), .in_tvalid(in_tvalid), .in_tready(in_tready),
  .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
  .b_valid(b_valid), .b_ready(b_ready), .sts_valid(sts_valid), .sts_ready(sts_ready),
  .sts_data(sts_data), .sts_last(sts_last), .addr_posted(addr_posted),
  .next_len_load(next_len_load), .next_len(next_len), .xfer_done(xfer_done)
);

// File: tb/s2mm_burst_writer_tb.sv
`timescale 1ns/1ps
module s2mm_burst_writer_tb_top;
  localparam int WD_LIMIT = 150000;

  typedef struct packed {
    logic [31:0] d;
    logic [3:0]  k;
    logic        l;
  } beat_t;

  logic        clk, rst_n;
  logic        cmd_valid, cmd_ready;
  logic [58:0] cmd_data;
  logic        allow_addr_req;
  logic        in_tvalid, in_tready, in_tlast;
  logic [31:0] in_tdata;
  logic [3:0]  in_tkeep;
  logic        aw_valid, aw_ready;
  logic [31:0] aw_addr;
  logic [7:0]  aw_len, next_len;
  logic [2:0]  aw_size;
  logic [1:0]  aw_burst, b_resp;
  logic        w_valid, w_ready, w_last;
  logic [31:0] w_data;
  logic [3:0]  w_strb;
  logic        b_valid, b_ready;
  logic        sts_valid, sts_ready, sts_last;
  logic [7:0]  sts_data;
  logic        addr_posted, xfer_done, next_len_load;

  s2mm_burst_writer dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .allow_addr_req(allow_addr_req),
    .in_tvalid(in_tvalid), .in_tready(in_tready), .in_tdata(in_tdata),
    .in_tkeep(in_tkeep), .in_tlast(in_tlast),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
    .aw_size(aw_size), .aw_burst(aw_burst),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb),
    .w_last(w_last), .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
    .sts_valid(sts_valid), .sts_ready(sts_ready), .sts_data(sts_data),
    .sts_last(sts_last), .addr_posted(addr_posted), .xfer_done(xfer_done),
    .next_len_load(next_len_load), .next_len(next_len)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // stimulus and reference queues
  beat_t       src_q[$];
  beat_t       wexp_q[$];
  logic [58:0] cmd_q[$];
  logic [39:0] awexp_q[$];   // {addr, len}
  int          len_q[$];     // lengths of accepted bursts awaiting data
  logic [2:0]  bplan_q[$];   // {final_of_command, resp}
  logic [7:0]  sts_q[$];

  int  n_tests, n_fail, cyc, acc_cnt, aw_cnt, wcnt, bpend;
  bit  timeout, cmd_en, allow_low, src_stuck, b_stuck;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // expected child bursts, stream beats and status for one command (R6, R9, R10)
  task automatic gen_cmd(input logic [31:0] addr, input int btt, input logic [3:0] tag,
                         input int kind, input int resp_mode);
    int          words, n, b, t;
    logic [31:0] a;
    logic [1:0]  r;
    bit          rerr, kerr, lerr, first;
    beat_t       bt;
    logic [3:0]  fin_keep;
    a = {addr[31:2], 2'b00};
    words = (btt + 3) / 4;
    n = words;
    rerr = 0; kerr = 0; lerr = 0; first = 1;
    if (n < 2 && kind >= 1 && kind <= 3) kind = 4;
    case (btt % 4)
      1: fin_keep = 4'h1;
      2: fin_keep = 4'h3;
      3: fin_keep = 4'h7;
      default: fin_keep = 4'hF;
    endcase
    for (int i = 0; i < n; i++) begin
      bt.d = $urandom;
      bt.k = (i == n - 1) ? fin_keep : 4'hF;
      bt.l = (i == n - 1);
      if (i == 0 && kind == 1) bt.k = 4'h0;
      if (i == 0 && kind == 2) bt.k = 4'h3;
      if (i == 0 && kind == 3) bt.l = 1'b1;
      if (i == n - 1 && kind == 4) bt.l = 1'b0;
      if (bt.k == 4'h0 || (!bt.l && bt.k != 4'hF)) kerr = 1;
      if (bt.l != (i == n - 1)) lerr = 1;
      src_q.push_back(bt);
    end
    while (words > 0) begin
      t = 1024 - int'(a[11:2]);
      b = (words < 16) ? words : 16;
      if (t < b) b = t;
      awexp_q.push_back({a, 8'(b - 1)});
      r = 2'b00;
      if (resp_mode == 1 && ($urandom % 10) == 0) r = 2'b10 | 2'($urandom % 2);
      if (resp_mode == 2 && first) r = 2'b10;
      if (resp_mode == 3 && first) r = 2'b11;
      if (r[1]) rerr = 1;
      first = 0;
      words -= b;
      bplan_q.push_back({words == 0, r});
      a += 32'(4 * b);
    end
    cmd_q.push_back({addr[31:2], 2'b00, 23'(btt), tag});
    sts_q.push_back({!(rerr || kerr || lerr), lerr, kerr, rerr, tag});
  endtask

  task automatic step();
    int   lenf;
    beat_t e;
    logic [39:0] ae;
    logic [2:0]  be;
    @(negedge clk);
    cyc++;
    if (cyc == WD_LIMIT) begin
      timeout = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
    end
    in_tvalid = (src_q.size() > 0) && (src_stuck || ($urandom % 5) != 0);
    if (src_q.size() > 0) {in_tdata, in_tkeep, in_tlast} = src_q[0];
    cmd_valid = cmd_en && (cmd_q.size() > 0);
    cmd_data  = (cmd_q.size() > 0) ? cmd_q[0] : '0;
    allow_addr_req = allow_low ? 1'b0 : (($urandom % 3) != 0);
    aw_ready  = ($urandom % 3) != 0;
    w_ready   = ($urandom % 4) != 0;
    sts_ready = ($urandom % 3) != 0;
    b_valid   = (bpend > 0) && (b_stuck || ($urandom % 3) != 0);
    b_resp    = (bplan_q.size() > 0) ? bplan_q[0][1:0] : 2'b00;
    #1;
    src_stuck = in_tvalid && !in_tready;
    b_stuck   = b_valid && !b_ready;
    if (in_tvalid && in_tready) begin
      wexp_q.push_back(src_q.pop_front());
      acc_cnt++;
    end
    if (cmd_valid && cmd_ready) void'(cmd_q.pop_front());
    if (aw_valid && aw_ready) begin
      aw_cnt++;
      if (awexp_q.size() == 0) chk(0, "R6 unexpected burst", aw_addr, 0);
      else begin
        ae = awexp_q.pop_front();
        chk(aw_addr == ae[39:8], "R6 burst address", aw_addr, ae[39:8]);
        chk(aw_len == ae[7:0], "R6 burst length", aw_len, ae[7:0]);
        chk(aw_size == 3'd2 && aw_burst == 2'b01, "R6 size/type", {aw_size, aw_burst}, 5'b01001);
        chk(addr_posted, "R2 address posted pulse", addr_posted, 1);
        chk(next_len_load && next_len == aw_len, "R5 next length", {next_len_load, next_len}, {1'b1, aw_len});
        len_q.push_back(int'(ae[7:0]));
      end
    end else if (addr_posted || next_len_load) begin
      chk(0, "R2 pulse without address handshake", {addr_posted, next_len_load}, 0);
    end
    if (w_valid && w_ready) begin
      if (wexp_q.size() == 0 || len_q.size() == 0) chk(0, "R4 unexpected data beat", w_data, 0);
      else begin
        e = wexp_q.pop_front();
        lenf = len_q[0];
        chk(w_data == e.d, "R4 write data", w_data, e.d);
        chk(w_strb == e.k, "R4 write strobe", w_strb, e.k);
        chk(w_last == (wcnt == lenf), "R4 burst last", w_last, wcnt == lenf);
        if (wcnt == lenf) begin
          void'(len_q.pop_front());
          wcnt = 0;
          bpend++;
        end else wcnt++;
      end
    end
    if (b_valid && b_ready) begin
      be = bplan_q.pop_front();
      bpend--;
      chk(xfer_done == be[2], "R7 transfer done pulse", xfer_done, be[2]);
    end else if (xfer_done) begin
      chk(0, "R7 transfer done outside response", xfer_done, 0);
    end
    if (sts_valid && sts_ready) begin
      if (sts_q.size() == 0) chk(0, "R8 unexpected status", sts_data, 0);
      else begin
        chk(sts_data == sts_q[0], "R9 status word", sts_data, sts_q[0]);
        chk(sts_last, "R8 status single beat", sts_last, 1);
        void'(sts_q.pop_front());
      end
    end
  endtask

  initial begin
    int r, kind, btt;
    logic [31:0] a;
    void'($urandom(32'h5EED_0042));
    n_tests = 0; n_fail = 0; cyc = 0; acc_cnt = 0; aw_cnt = 0; wcnt = 0; bpend = 0;
    timeout = 0; cmd_en = 0; allow_low = 0; src_stuck = 0; b_stuck = 0;
    rst_n = 1'b0;
    cmd_valid = 0; cmd_data = '0; allow_addr_req = 0;
    in_tvalid = 0; in_tdata = '0; in_tkeep = '0; in_tlast = 0;
    aw_ready = 0; w_ready = 0; b_valid = 0; b_resp = '0; sts_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    step();
    chk(cmd_ready, "R10 ready for a command after reset", cmd_ready, 1);
    chk(!aw_valid && !w_valid && !b_ready, "R7 idle memory side after reset",
        {aw_valid, w_valid, b_ready}, 0);
    chk(!sts_valid, "R8 no status after reset", sts_valid, 0);
    chk(in_tready, "R3 stream accepted after reset", in_tready, 1);

    // prefetch throttle: six beats offered, no command yet
    gen_cmd(32'h0000_1000, 24, 4'h1, 0, 0);
    repeat (12) step();
    chk(acc_cnt == 4, "R3 beats taken without command", acc_cnt, 4);
    chk(!in_tready, "R3 stream held off", in_tready, 0);

    // address permission withheld
    allow_low = 1; cmd_en = 1;
    repeat (10) step();
    chk(aw_cnt == 0 && !aw_valid, "R1 no address while permission low", {aw_cnt[7:0], aw_valid}, 0);
    chk(!cmd_ready, "R10 one command at a time", cmd_ready, 0);
    allow_low = 0;

    // directed splits and error flags
    gen_cmd(32'h0000_1FF8, 40, 4'h2, 0, 0);   // 2 beats then 8 at the page
    gen_cmd(32'h0000_3000, 100, 4'h3, 0, 0);  // 16 then 9
    gen_cmd(32'h0000_4FFC, 5, 4'h4, 0, 0);    // 1 then 1, partial keep on final
    gen_cmd(32'h0000_5000, 64, 4'h5, 0, 2);   // SLVERR on first child
    gen_cmd(32'h0000_6000, 12, 4'h6, 1, 3);   // null keep plus DECERR
    gen_cmd(32'h0000_7000, 20, 4'h7, 2, 0);   // partial keep mid packet
    gen_cmd(32'h0000_8000, 16, 4'h8, 3, 0);   // early end of packet
    gen_cmd(32'h0000_9000, 9, 4'h9, 4, 0);    // missing end of packet
    gen_cmd(32'h0000_A000, 4, 4'hA, 0, 0);    // single full beat

    for (int i = 0; i < 40; i++) begin
      r = int'($urandom % 10);
      kind = (r < 6) ? 0 : r - 5;
      btt = 1 + int'($urandom % 160);
      a = $urandom;
      if (($urandom % 2) == 0) a[11:0] = 12'hFC0 + 12'($urandom % 64);
      gen_cmd(a, btt, 4'($urandom), kind, 1);
    end

    while ((sts_q.size() > 0 || cmd_q.size() > 0) && !timeout) step();
    repeat (4) step();
    chk(awexp_q.size() == 0 && bplan_q.size() == 0 && src_q.size() == 0,
        "R8 every command fully processed",
        {awexp_q.size(), bplan_q.size()}, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule